// File: doc/BRIEF.md
# Strobed Serial Register Target

This block is the device side of a three-wire bit-serial register link that a host drives from general-purpose pins. The host framing uses an active-low clear line, a strobe line and a data-in line, and the block answers on a separate data-out line. All three host lines are oversampled by the block's own system clock through two-flop synchronizers. Strobe rising edges are then detected in the system-clock domain. Each frame starts when clear is pulsed low. An 8-bit header follows: the first bit selects read or write, and the next seven bits give the register address. Sixteen data bits then move in or out.

Behind the link sits a small register bank. Two read-only identification words carry a platform code and a firmware version. Writable function-enable, pin-enable and pin-direction words are driven straight out to the pin-multiplexing logic.

The control is a four-state machine. `ST_WAIT` ignores strobes. `ST_HDR` collects header bits. `ST_WDATA` collects write data. `ST_RDATA` shifts read data out.

The transitions are:
- any state goes to `ST_HDR` while clear is low;
- `ST_HDR` goes to `ST_RDATA` or `ST_WDATA` on the eighth header strobe, according to the read flag;
- `ST_WDATA` goes to `ST_WAIT` on the sixteenth data strobe;
- `ST_RDATA` goes to `ST_WAIT` on the strobe that follows the sixteenth presented bit.

The out-of-reset state is `ST_WAIT`.

Top module: `strobe_regslave`

## Requirements
- R1: After reset, every writable word reads 0x0000, the three output buses are all zero and data-out is 0.
- R2: A frame starts when clear returns high. Each data-in bit is captured on a strobe rising edge. The first 8 captured bits form the header, most significant bit first: header bit 7 is the read flag (1 = read, 0 = write) and header bits 6..0 are the address.
- R3: In a write frame, the 16 data bits that follow the header are captured most significant bit first. The addressed word takes the value once the 16th bit is captured. Function-enable word k (address 0x20+k, k = 0..1) appears on func_en_o[16k+15:16k]. Pin-enable word k (address 0x30+k, k = 0..2) appears on pin_en_o[16k+15:16k]. Pin-direction word k (address 0x40+k) appears on pin_dir_o[16k+15:16k].
- R4: In a read frame, the addressed word is shifted out most significant bit first. Data bit 15 appears on data-out after the first strobe rising edge of the data phase, and each further rising edge presents the next bit. The host samples after each strobe fall.
- R5: Address 0x10 reads {board code, 0x01}; the default board code is 0x5A. Address 0x11 reads {build[15:12], major[11:8], minor[7:4], patch[3:0]}. Major is always 0, and the defaults are build 3, minor 2 and patch 7, giving 0x3027.
- R6: A write frame aimed at 0x10, 0x11 or any unmapped address changes no register and no output bus.
- R7: A read of any address outside 0x10–0x11, 0x20–0x21, 0x30–0x32 and 0x40–0x42 returns 0x0000.
- R8: A low pulse on clear abandons a partly sent frame. A write abandoned before its 16th data bit changes nothing, and data-out returns to 0.
- R9: Strobe edges after a complete frame are ignored until the next clear pulse. They cause no write, and data-out stays 0.
- R10: Data-out is 0 at all times outside the read data phase, including during the header and after a read ends.
- R11: A completed write changes only the addressed word's slice of the output buses. The buses never change without a completed write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the host lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_n_pin | input | 1 | Host clear line, active low, starts a new frame |
| stb_pin | input | 1 | Host strobe line, data-in sampled on its rising edge |
| din_pin | input | 1 | Host serial data toward the block |
| dout_pin | output | 1 | Serial read data toward the host |
| func_en_o | output | NUM_FUNC*16 | Function-enable words, word k in bits [16k+15:16k] |
| pin_en_o | output | NUM_PIN*16 | Pin-enable words, word k in bits [16k+15:16k] |
| pin_dir_o | output | NUM_PIN*16 | Pin-direction words, word k in bits [16k+15:16k] |

## Verification
The bench writes a distinct value to every one of the 128 addresses and then reads all 128 back. A decoder that aliased an unmapped or identification address onto a writable word would therefore show up as a corrupted bus slice or a wrong readback. A shifter off by one strobe would return words rotated by one bit. Abandoned frames are cut after seven data bits; a design that let clear leave the counter running would commit a garbage word. Trailing strobes with data-in held high follow a finished write; a machine that re-entered the header phase without a clear would write or drive data-out.

// File: rtl/srs_pkg.sv
package srs_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 16;
    localparam int HDR_W  = ADDR_W + 1;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_HDR   = 2'd1,
        ST_WDATA = 2'd2,
        ST_RDATA = 2'd3
    } srs_state_e;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta[g] <= RST_VAL[g];
                q[g]    <= RST_VAL[g];
            end else begin
                meta[g] <= d[g];
                q[g]    <= meta[g];
            end
        end
    end
endmodule

// File: rtl/srs_frame_fsm.sv
module srs_frame_fsm
    import srs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_s,
    input  logic              stb_rise,
    input  logic              din_s,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] look_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              dout,
    output srs_state_e        state
);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] RD_END   = CNT_W'(DATA_W);

    srs_state_e        nxt;
    logic [CNT_W-1:0]  cnt;
    logic [HDR_W-2:0]  hdr_sr;
    logic [DATA_W-1:0] data_sr;
    logic              rd_flag;

    // After seven captures the first header bit sits at the top of hdr_sr.
    assign rd_flag   = hdr_sr[HDR_W-2];
    assign look_addr = {hdr_sr[ADDR_W-2:0], din_s};

    // Next-state logic
    always_comb begin
        nxt = state;
        if (!clr_s) begin
            nxt = ST_HDR;
        end else if (stb_rise) begin
            unique case (state)
                ST_WAIT:  nxt = ST_WAIT;
                ST_HDR:   if (cnt == HDR_LAST) nxt = rd_flag ? ST_RDATA : ST_WDATA;
                ST_WDATA: if (cnt == WR_LAST)  nxt = ST_WAIT;
                ST_RDATA: if (cnt == RD_END)   nxt = ST_WAIT;
                default:  nxt = ST_WAIT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= nxt;
    end

    // Bit counter and shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            hdr_sr  <= '0;
            data_sr <= '0;
            wr_addr <= '0;
        end else if (!clr_s) begin
            cnt    <= '0;
            hdr_sr <= '0;
        end else if (stb_rise) begin
            unique case (state)
                ST_HDR: begin
                    hdr_sr <= {hdr_sr[HDR_W-3:0], din_s};
                    if (cnt == HDR_LAST) begin
                        cnt     <= '0;
                        wr_addr <= look_addr;
                        data_sr <= rd_word;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WDATA: begin
                    data_sr <= {data_sr[DATA_W-2:0], din_s};
                    cnt     <= cnt + 1'b1;
                end
                ST_RDATA: begin
                    data_sr <= {data_sr[DATA_W-2:0], 1'b0};
                    if (cnt != RD_END) cnt <= cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs: serial data-out and write pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= 1'b0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (!clr_s) begin
                dout <= 1'b0;
            end else if (stb_rise) begin
                unique case (state)
                    ST_WDATA: begin
                        if (cnt == WR_LAST) begin
                            wr_en   <= 1'b1;
                            wr_data <= {data_sr[DATA_W-2:0], din_s};
                        end
                    end
                    ST_RDATA: dout <= (cnt == RD_END) ? 1'b0 : data_sr[DATA_W-1];
                    default:  dout <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/srs_regbank.sv
module srs_regbank
    import srs_pkg::*;
#(
    parameter int                NUM_FUNC    = 2,
    parameter int                NUM_PIN     = 3,
    parameter int                FUNC_BASE   = 'h20,
    parameter int                PINEN_BASE  = 'h30,
    parameter int                PINDIR_BASE = 'h40,
    parameter int                PLAT_ADDR   = 'h10,
    parameter int                FWID_ADDR   = 'h11,
    parameter logic [DATA_W-1:0] PLAT_WORD   = 16'h5A01,
    parameter logic [DATA_W-1:0] FWID_WORD   = 16'h3027
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_FUNC*DATA_W-1:0] func_en,
    output logic [NUM_PIN*DATA_W-1:0]  pin_en,
    output logic [NUM_PIN*DATA_W-1:0]  pin_dir
);
    logic [DATA_W-1:0] func_q [NUM_FUNC];
    logic [DATA_W-1:0] pen_q  [NUM_PIN];
    logic [DATA_W-1:0] pdir_q [NUM_PIN];

    for (genvar g = 0; g < NUM_FUNC; g++) begin : g_func
        localparam logic [ADDR_W-1:0] A = ADDR_W'(FUNC_BASE + g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       func_q[g] <= '0;
            else if (wr_en && wr_addr == A)   func_q[g] <= wr_data;
        end
        assign func_en[g*DATA_W +: DATA_W] = func_q[g];
    end

    for (genvar g = 0; g < NUM_PIN; g++) begin : g_pin
        localparam logic [ADDR_W-1:0] AE = ADDR_W'(PINEN_BASE + g);
        localparam logic [ADDR_W-1:0] AD = ADDR_W'(PINDIR_BASE + g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pen_q[g]  <= '0;
                pdir_q[g] <= '0;
            end else if (wr_en) begin
                if (wr_addr == AE) pen_q[g]  <= wr_data;
                if (wr_addr == AD) pdir_q[g] <= wr_data;
            end
        end
        assign pin_en[g*DATA_W +: DATA_W]  = pen_q[g];
        assign pin_dir[g*DATA_W +: DATA_W] = pdir_q[g];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(PLAT_ADDR)) rd_data = PLAT_WORD;
        if (rd_addr == ADDR_W'(FWID_ADDR)) rd_data = FWID_WORD;
        for (int i = 0; i < NUM_FUNC; i++)
            if (rd_addr == ADDR_W'(FUNC_BASE + i)) rd_data = func_q[i];
        for (int i = 0; i < NUM_PIN; i++) begin
            if (rd_addr == ADDR_W'(PINEN_BASE + i))  rd_data = pen_q[i];
            if (rd_addr == ADDR_W'(PINDIR_BASE + i)) rd_data = pdir_q[i];
        end
    end
endmodule

// File: rtl/strobe_regslave.sv
module strobe_regslave
    import srs_pkg::*;
#(
    parameter int          NUM_FUNC    = 2,
    parameter int          NUM_PIN     = 3,
    parameter int          FUNC_BASE   = 'h20,
    parameter int          PINEN_BASE  = 'h30,
    parameter int          PINDIR_BASE = 'h40,
    parameter logic [7:0]  BOARD_CODE  = 8'h5A,
    parameter logic [3:0]  FW_BUILD    = 4'h3,
    parameter logic [3:0]  FW_MINOR    = 4'h2,
    parameter logic [3:0]  FW_PATCH    = 4'h7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_n_pin,
    input  logic                       stb_pin,
    input  logic                       din_pin,
    output logic                       dout_pin,
    output logic [NUM_FUNC*DATA_W-1:0] func_en_o,
    output logic [NUM_PIN*DATA_W-1:0]  pin_en_o,
    output logic [NUM_PIN*DATA_W-1:0]  pin_dir_o
);
    localparam logic [7:0]        MFR_CODE  = 8'h01;
    localparam logic [DATA_W-1:0] PLAT_WORD = {BOARD_CODE, MFR_CODE};
    localparam logic [DATA_W-1:0] FWID_WORD = {FW_BUILD, 4'h0, FW_MINOR, FW_PATCH};

    logic              clr_s, stb_s, din_s, stb_q, stb_rise;
    logic [ADDR_W-1:0] look_addr, wr_addr;
    logic [DATA_W-1:0] rd_word, wr_data;
    logic              wr_en;
    srs_state_e        state;

    srs_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({clr_n_pin, stb_pin, din_pin}),
        .q     ({clr_s, stb_s, din_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_q <= 1'b1;
        else        stb_q <= stb_s;
    end
    assign stb_rise = stb_s & ~stb_q;

    srs_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_s     (clr_s),
        .stb_rise  (stb_rise),
        .din_s     (din_s),
        .rd_word   (rd_word),
        .look_addr (look_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .dout      (dout_pin),
        .state     (state)
    );

    srs_regbank #(
        .NUM_FUNC    (NUM_FUNC),
        .NUM_PIN     (NUM_PIN),
        .FUNC_BASE   (FUNC_BASE),
        .PINEN_BASE  (PINEN_BASE),
        .PINDIR_BASE (PINDIR_BASE),
        .PLAT_WORD   (PLAT_WORD),
        .FWID_WORD   (FWID_WORD)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (look_addr),
        .rd_data (rd_word),
        .func_en (func_en_o),
        .pin_en  (pin_en_o),
        .pin_dir (pin_dir_o)
    );
endmodule

// File: rtl/srs_checker.sv
module srs_checker
    import srs_pkg::*;
#(
    parameter int FW = 32,
    parameter int PW = 48
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr_s,
    input logic          wr_en,
    input logic          dout_pin,
    input srs_state_e    state,
    input logic [FW-1:0] func_en_o,
    input logic [PW-1:0] pin_en_o,
    input logic [PW-1:0] pin_dir_o
);
    assert_dout_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RDATA) |-> !dout_pin);

    assert_clear_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> (state == ST_HDR && !dout_pin));

    assert_extra_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && clr_s) |=> (state == ST_WAIT));

    assert_bus_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(func_en_o) && $stable(pin_en_o) && $stable(pin_dir_o)));

    assert_write_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == ST_WAIT));
endmodule

bind strobe_regslave srs_checker #(
    .FW (NUM_FUNC*DATA_W),
    .PW (NUM_PIN*DATA_W)
) u_srs_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_s     (clr_s),
    .wr_en     (wr_en),
    .dout_pin  (dout_pin),
    .state     (state),
    .func_en_o (func_en_o),
    .pin_en_o  (pin_en_o),
    .pin_dir_o (pin_dir_o)
);

// File: tb/strobe_regslave_bench.sv
`timescale 1ns/1ps
module strobe_regslave_bench;
    localparam int HP = 4;   // strobe half period in clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_n = 1'b1, stb = 1'b1, din = 1'b0;
    logic        dout;
    logic [31:0] func_en;
    logic [47:0] pin_en, pin_dir;

    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;
    logic [15:0] model [128];

    always #4 clk = ~clk;

    strobe_regslave u_strobe_regslave (
        .clk(clk), .rst_n(rst_n), .clr_n_pin(clr_n), .stb_pin(stb), .din_pin(din),
        .dout_pin(dout), .func_en_o(func_en), .pin_en_o(pin_en), .pin_dir_o(pin_dir)
    );

    function automatic bit writable(int a);
        return (a >= 'h20 && a <= 'h21) || (a >= 'h30 && a <= 'h32) || (a >= 'h40 && a <= 'h42);
    endfunction

    function automatic logic [15:0] wval(int a);
        return 16'((a + 1) * 16'h0B3D) ^ 16'h6C81;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_buses(input string tag);
        logic [31:0] ef;
        logic [47:0] ee, ed;
        for (int k = 0; k < 2; k++) ef[k*16 +: 16] = model['h20 + k];
        for (int k = 0; k < 3; k++) begin
            ee[k*16 +: 16] = model['h30 + k];
            ed[k*16 +: 16] = model['h40 + k];
        end
        chk(func_en == ef, tag, 64'(func_en), 64'(ef));
        chk(pin_en == ee, tag, 64'(pin_en), 64'(ee));
        chk(pin_dir == ed, tag, 64'(pin_dir), 64'(ed));
    endtask

    task automatic clr_pulse();
        clr_n = 1'b0; wait_clk(HP);
        clr_n = 1'b1; wait_clk(HP);
    endtask

    task automatic put_bit(input logic b);
        stb = 1'b0; din = b; wait_clk(HP);
        stb = 1'b1; wait_clk(HP);
    endtask

    task automatic send_hdr(input logic rd, input int a);
        logic [7:0] h;
        h = {rd, 7'(a)};
        clr_pulse();
        for (int i = 7; i >= 0; i--) put_bit(h[i]);
        stb = 1'b0; wait_clk(HP);
    endtask

    task automatic do_write(input int a, input logic [15:0] v);
        send_hdr(1'b0, a);
        for (int i = 15; i >= 0; i--) begin
            din = v[i]; wait_clk(1);
            stb = 1'b1; wait_clk(HP);
            stb = 1'b0; wait_clk(HP - 1);
        end
        stb = 1'b1; wait_clk(HP + 2);
    endtask

    task automatic do_read(input int a, output logic [15:0] v);
        send_hdr(1'b1, a);
        chk(dout == 1'b0, "R10 header", 64'(dout), 64'd0);
        for (int i = 15; i >= 0; i--) begin
            stb = 1'b1; wait_clk(HP);
            stb = 1'b0; wait_clk(HP);
            v[i] = dout;
        end
        stb = 1'b1; wait_clk(HP);
        chk(dout == 1'b0, "R10 after read", 64'(dout), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        string tag;
        for (int a = 0; a < 128; a++) model[a] = '0;
        model['h10] = {8'h5A, 8'h01};
        model['h11] = {4'h3, 4'h0, 4'h2, 4'h7};

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        // R1: reset state
        check_buses("R1 reset");
        chk(dout == 1'b0, "R1 dout", 64'(dout), 64'd0);

        // Read sweep before any write: R1, R5, R7
        for (int a = 0; a < 128; a++) begin
            do_read(a, v);
            tag = (a == 'h10 || a == 'h11) ? "R5" : (writable(a) ? "R1" : "R7");
            chk(v == model[a], tag, 64'(v), 64'(model[a]));
        end
        do_read('h11, v);
        chk(v[11:8] == 4'h0, "R5 major", 64'(v[11:8]), 64'd0);

        // Write sweep over all addresses: R2, R3, R6, R11
        for (int a = 0; a < 128; a++) begin
            do_write(a, wval(a));
            if (writable(a)) model[a] = wval(a);
            check_buses(writable(a) ? "R2 R3 R11" : "R6");
        end

        // Read sweep after writes: R4, R5, R6, R7
        for (int a = 0; a < 128; a++) begin
            do_read(a, v);
            tag = (a == 'h10 || a == 'h11) ? "R5 R6" : (writable(a) ? "R4" : "R7");
            chk(v == model[a], tag, 64'(v), 64'(model[a]));
        end

        // R8: partial write abandoned by clear
        send_hdr(1'b0, 'h31);
        for (int i = 0; i < 7; i++) begin
            din = 1'b1; wait_clk(1);
            stb = 1'b1; wait_clk(HP);
            stb = 1'b0; wait_clk(HP - 1);
        end
        clr_pulse();
        check_buses("R8 aborted write");
        do_read('h31, v);
        chk(v == model['h31], "R8 readback", 64'(v), 64'(model['h31]));

        // R8: read abandoned mid data phase
        send_hdr(1'b1, 'h10);
        for (int i = 0; i < 5; i++) begin
            stb = 1'b1; wait_clk(HP);
            stb = 1'b0; wait_clk(HP);
        end
        clr_pulse();
        chk(dout == 1'b0, "R8 R10 aborted read", 64'(dout), 64'd0);

        // R9: trailing strobes after a complete write
        do_write('h21, 16'h8001);
        model['h21] = 16'h8001;
        check_buses("R3 edge value");
        for (int i = 0; i < 20; i++) begin
            put_bit(1'b1);
            chk(dout == 1'b0, "R9 dout", 64'(dout), 64'd0);
        end
        check_buses("R9 no write");
        do_read('h21, v);
        chk(v == 16'h8001, "R9 R4 readback", 64'(v), 64'h8001);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule